// File: doc/BRIEF.md
# Instruction Issue and Skip Sequencer

This block sits between the program-word fetch stage and the execute stage of a small processor with 24-bit instruction words. On every clock it hands the execute stage exactly one slot. The slot holds either a fetched word or a bubble, which is an all-zero NOP word. The block also tells the fetch stage when the word it is presenting has been taken, and when the program counter has been redirected. Decode results come in as sideband hints with each fetched word:
- a flag marking the first half of a two-word instruction;
- the result of a skip condition;
- a flag for instructions that change the program counter;
- a 2-bit class giving the cycle cost of a single-word instruction;
- a lookahead flag that says whether the following word starts a two-word instruction.

The sequencer turns these hints into the right cycle accounting. Multi-cycle instructions are followed by held bubble cycles. A branch costs at least one extra cycle, and in that cycle the stale sequential word is thrown away while a one-cycle flush pulse is raised. A taken skip discards either one word or two, depending on the lookahead flag. A word whose upper byte is zero and that arrives outside the second-half position is executed as a harmless NOP, and every hint that came with it is ignored. A running count of NOP slots lets the cycle cost of each instruction class be checked from outside.

Top module: `issue_seq`

## Requirements
- R1: A synchronous active-high reset clears all state. In the first cycle after reset the slot is a bubble (issue_nop=1, issue_word=0), fetch_adv=0, and nop_count reads 0. A word is taken and issued in the cycle after that.
- R2: A valid word with no flags set and class 0 or 1 is issued in the cycle it is presented. In that cycle fetch_adv=1 and issue_nop=0, and the next word is taken in the following cycle.
- R3: A single-word instruction of class 2 or class 3 that does not change the PC is followed by 1 or 2 bubble cycles respectively. In those bubble cycles fetch_adv=0.
- R4: A single-word PC-changing instruction asserts pc_redirect in its issue cycle and costs max(class,2) cycles in total. In the first bubble cycle flush=1 and fetch_adv=1, which discards the stale word. Any later bubble cycles have flush=0 and fetch_adv=0.
- R5: A word with the double-word flag is issued and then followed by its second word in the next available cycle. The second word is issued with issue_ext=1 and issue_nop=0. If the first word carried the PC-change flag, pc_redirect is raised together with the second word, and one flush bubble follows.
- R6: A taken skip whose lookahead flag is 0 is followed by one bubble cycle. That cycle consumes the skipped word (fetch_adv=1).
- R7: A taken skip whose lookahead flag is 1 is followed by two bubble cycles. Each of them consumes one skipped word.
- R8: A word presented for first-word issue whose bits [23:16] are all zero is issued with issue_nop=1 and issue_ext=0. All of its hints are ignored: there is no redirect and no bubble, and the next word is issued in the next cycle.
- R9: While fetch_valid=0 and a word is needed, the slot is a bubble, fetch_adv=0, and any pending second-word state is kept.
- R10: nop_count increases by one for every cycle in which issue_nop=1 outside reset, and it saturates at all ones.
- R11: pc_redirect and flush are never high in the same cycle, and flush is high only in the cycle right after pc_redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A fetched word is presented |
| fetch_word | input | 24 | Presented instruction word |
| hint_dword | input | 1 | Word is the first half of a two-word instruction |
| hint_skip | input | 1 | Skip condition evaluated true |
| hint_pc_chg | input | 1 | Instruction changes the PC |
| hint_class | input | 2 | Cycle cost of a single-word instruction (0 and 1 mean one cycle) |
| hint_next_dword | input | 1 | Lookahead: the following word starts a two-word instruction |
| fetch_adv | output | 1 | Presented word is taken or discarded this cycle |
| issue_word | output | 24 | Word sent to execute (zero on a bubble) |
| issue_nop | output | 1 | Slot executes as a NOP |
| issue_ext | output | 1 | Slot carries the second half of a two-word instruction |
| pc_redirect | output | 1 | PC is being redirected this cycle |
| flush | output | 1 | Stale fetched word is discarded this cycle |
| nop_count | output | 16 | Running count of NOP slots |

## Verification
Most internal faults show up at the ports within one to three cycles. A bubble or skip counter that is off by one either takes a word too early or holds fetch_adv low for one cycle too long, and the next instruction then appears in the wrong cycle. A lost second-word marker shows up as a 00-prefixed operand that is issued with issue_nop high and no issue_ext. A pending redirect that is dropped removes the flush pulse that should follow. The cumulative nop_count carries any miscounted cycle forward, so a slip is still visible in the final total after the cycle where it happened.

// File: rtl/issue_seq_pkg.sv
`timescale 1ns/1ps
package issue_seq_pkg;

   localparam int CLS_W = 2;

   typedef enum logic [1:0] {
      SLOT_BUBBLE = 2'd0,
      SLOT_FIRST  = 2'd1,
      SLOT_SECOND = 2'd2
   } slot_e;

   // Bubble cycles that follow a single-word instruction of a given class.
   function automatic logic [1:0] extra_bubbles(input logic [CLS_W-1:0] cls,
                                                input logic pc_chg);
      logic [1:0] cost;
      cost = (cls < 2'd2) ? 2'd1 : cls;
      if (pc_chg && cost < 2'd2) cost = 2'd2;
      return cost - 2'd1;
   endfunction

endpackage

// File: rtl/issue_seq_ctrl.sv
`timescale 1ns/1ps
module issue_seq_ctrl
   import issue_seq_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             fetch_valid,
   input  logic             stray,
   input  logic             dword,
   input  logic             skip,
   input  logic             pc_chg,
   input  logic [CLS_W-1:0] cls,
   input  logic             next_dword,
   output slot_e            slot,
   output logic             fetch_adv,
   output logic             pc_redirect,
   output logic             flush
);

   logic       boot_q, boot_d;
   logic [1:0] bub_q, bub_d;
   logic [1:0] skip_q, skip_d;
   logic       sec_q, sec_d;
   logic       rpend_q, rpend_d;
   logic       fpend_q, fpend_d;

   always_comb begin
      slot        = SLOT_BUBBLE;
      fetch_adv   = 1'b0;
      pc_redirect = 1'b0;
      flush       = 1'b0;
      boot_d      = boot_q;
      bub_d       = bub_q;
      skip_d      = skip_q;
      sec_d       = sec_q;
      rpend_d     = rpend_q;
      fpend_d     = fpend_q;
      if (rst) begin
         boot_d = 1'b1;
      end else if (boot_q) begin
         boot_d = 1'b0;
      end else if (skip_q != 2'd0) begin
         if (fetch_valid) begin
            fetch_adv = 1'b1;
            skip_d    = skip_q - 2'd1;
         end
      end else if (bub_q != 2'd0) begin
         flush     = fpend_q;
         fetch_adv = fpend_q;
         fpend_d   = 1'b0;
         bub_d     = bub_q - 2'd1;
      end else if (sec_q) begin
         if (fetch_valid) begin
            fetch_adv = 1'b1;
            slot      = SLOT_SECOND;
            sec_d     = 1'b0;
            if (rpend_q) begin
               pc_redirect = 1'b1;
               bub_d       = 2'd1;
               fpend_d     = 1'b1;
               rpend_d     = 1'b0;
            end
         end
      end else if (fetch_valid) begin
         fetch_adv = 1'b1;
         slot      = SLOT_FIRST;
         if (!stray) begin
            if (dword) begin
               sec_d   = 1'b1;
               rpend_d = pc_chg;
            end else if (skip) begin
               skip_d = next_dword ? 2'd2 : 2'd1;
            end else begin
               bub_d = extra_bubbles(cls, pc_chg);
               if (pc_chg) begin
                  pc_redirect = 1'b1;
                  fpend_d     = 1'b1;
               end
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         boot_q  <= 1'b1;
         bub_q   <= 2'd0;
         skip_q  <= 2'd0;
         sec_q   <= 1'b0;
         rpend_q <= 1'b0;
         fpend_q <= 1'b0;
      end else begin
         boot_q  <= boot_d;
         bub_q   <= bub_d;
         skip_q  <= skip_d;
         sec_q   <= sec_d;
         rpend_q <= rpend_d;
         fpend_q <= fpend_d;
      end
   end

   // R4
   redirect_then_flush_chk: assert property (@(posedge clk) disable iff (rst)
      pc_redirect |=> flush);

   // R11
   flush_only_after_redirect_chk: assert property (@(posedge clk) disable iff (rst)
      flush |-> $past(pc_redirect));

   // R11
   no_redirect_flush_overlap_chk: assert property (@(posedge clk) disable iff (rst)
      !(pc_redirect && flush));

   // R9
   no_adv_without_word_chk: assert property (@(posedge clk) disable iff (rst)
      (!fetch_valid && !flush) |-> !fetch_adv);

   // R1
   boot_slot_is_bubble_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!fetch_adv && slot == SLOT_BUBBLE));

endmodule

// File: rtl/issue_seq_slot.sv
`timescale 1ns/1ps
module issue_seq_slot
   import issue_seq_pkg::*;
#(
   parameter int WORD_W     = 24,
   parameter int PREFIX_W   = 8,
   parameter bit STRAY_TRAP = 1'b1
) (
   input  slot_e             slot,
   input  logic [WORD_W-1:0] fetch_word,
   output logic              stray,
   output logic [WORD_W-1:0] issue_word,
   output logic              issue_nop,
   output logic              issue_ext
);

   localparam int PFX_LSB = WORD_W - PREFIX_W;

   generate
      if (STRAY_TRAP) begin : g_trap
         assign stray = (fetch_word[WORD_W-1:PFX_LSB] == '0);
      end else begin : g_notrap
         assign stray = 1'b0;
      end
   endgenerate

   always_comb begin
      issue_word = (slot == SLOT_BUBBLE) ? '0 : fetch_word;
      issue_ext  = (slot == SLOT_SECOND);
      issue_nop  = (slot == SLOT_BUBBLE) || (slot == SLOT_FIRST && stray);
   end

   // R8
   ext_never_nop_chk: assert final (!(issue_ext && issue_nop));

endmodule

// File: rtl/issue_seq_nopctr.sv
`timescale 1ns/1ps
module issue_seq_nopctr #(
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             bump,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_q;
   logic             hold;

   generate
      if (SATURATE) begin : g_sat
         assign hold = (cnt_q == CNT_MAX);
      end else begin : g_wrap
         assign hold = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)              cnt_q <= '0;
      else if (bump && !hold) cnt_q <= cnt_q + CNT_ONE;
   end

   assign count = cnt_q;

   // R10
   nop_count_step_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(bump) && $past(cnt_q) != CNT_MAX) |-> cnt_q == $past(cnt_q) + CNT_ONE);

   // R10
   nop_count_idle_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(!bump)) |-> $stable(cnt_q));

endmodule

// File: rtl/issue_seq.sv
`timescale 1ns/1ps
module issue_seq
   import issue_seq_pkg::*;
#(
   parameter int WORD_W   = 24,
   parameter int PREFIX_W = 8,
   parameter int CNT_W    = 16,
   parameter bit CNT_SAT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fetch_valid,
   input  logic [WORD_W-1:0] fetch_word,
   input  logic              hint_dword,
   input  logic              hint_skip,
   input  logic              hint_pc_chg,
   input  logic [CLS_W-1:0]  hint_class,
   input  logic              hint_next_dword,
   output logic              fetch_adv,
   output logic [WORD_W-1:0] issue_word,
   output logic              issue_nop,
   output logic              issue_ext,
   output logic              pc_redirect,
   output logic              flush,
   output logic [CNT_W-1:0]  nop_count
);

   generate
      if (PREFIX_W < 1 || PREFIX_W >= WORD_W) begin : g_bad_prefix
         $error("issue_seq: PREFIX_W must lie in 1..WORD_W-1");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("issue_seq: CNT_W must be at least 2");
      end
   endgenerate

   slot_e slot;
   logic  stray;

   issue_seq_ctrl i_ctrl (
      .clk         (clk),
      .rst         (rst),
      .fetch_valid (fetch_valid),
      .stray       (stray),
      .dword       (hint_dword),
      .skip        (hint_skip),
      .pc_chg      (hint_pc_chg),
      .cls         (hint_class),
      .next_dword  (hint_next_dword),
      .slot        (slot),
      .fetch_adv   (fetch_adv),
      .pc_redirect (pc_redirect),
      .flush       (flush)
   );

   issue_seq_slot #(
      .WORD_W     (WORD_W),
      .PREFIX_W   (PREFIX_W),
      .STRAY_TRAP (1'b1)
   ) i_slot (
      .slot       (slot),
      .fetch_word (fetch_word),
      .stray      (stray),
      .issue_word (issue_word),
      .issue_nop  (issue_nop),
      .issue_ext  (issue_ext)
   );

   issue_seq_nopctr #(
      .CNT_W    (CNT_W),
      .SATURATE (CNT_SAT)
   ) i_nopctr (
      .clk   (clk),
      .rst   (rst),
      .bump  (issue_nop),
      .count (nop_count)
   );

endmodule

// File: tb/test_issue_seq.sv
`timescale 1ns/1ps
module test_issue_seq;

   typedef struct packed {
      logic        v;
      logic [23:0] w;
      logic        dw;
      logic        sk;
      logic        pc;
      logic [1:0]  cls;
      logic        nd;
      logic        e_adv;
      logic        e_nop;
      logic        e_ext;
      logic        e_red;
      logic        e_fl;
      logic [23:0] e_w;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 31;
   // fields: v, w, dw, sk, pc, cls, nd | adv, nop, ext, red, fl, word | req
   localparam vec_t VEC [NV] = '{
      '{1'b1,24'hA00001,1'b0,1'b0,1'b0,2'd0,1'b0, 1'b0,1'b1,1'b0,1'b0,1'b0,24'h000000,4'd1},  // R1 boot bubble
      '{1'b1,24'hA00001,1'b0,1'b0,1'b0,2'd0,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0,24'hA00001,4'd2},  // R2
      '{1'b1,24'hA00002,1'b0,1'b0,1'b0,2'd1,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0,24'hA00002,4'd2},  // R2
      '{1'b1,24'hA00003,1'b0,1'b0,1'b0,2'd2,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0,24'hA00003,4'd3},  // R3 class 2
      '{1'b1,24'hA00004,1'b0,1'b0,1'b0,2'd0,1'b0, 1'b0,1'b1,1'b0,1'b0,1'b0,24'h000000,4'd3},  // R3 bubble
      '{1'b1,24'hA00004,1'b0,1'b0,1'b0,2'd3,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0,24'hA00004,4'd3},  // R3 class 3
      '{1'b1,24'hA00005,1'b0,1'b0,1'b0,2'd0,1'b0, 1'b0,1'b1,1'b0,1'b0,1'b0,24'h000000,4'd3},  // R3
      '{1'b1,24'hA00005,1'b0,1'b0,1'b0,2'd0,1'b0, 1'b0,1'b1,1'b0,1'b0,1'b0,24'h000000,4'd3},  // R3
      '{1'b1,24'hA00005,1'b0,1'b0,1'b0,2'd0,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0,24'hA00005,4'd2},  // R2
      '{1'b1,24'hB00006,1'b0,1'b0,1'b1,2'd0,1'b0, 1'b1,1'b0,1'b0,1'b1,1'b0,24'hB00006,4'd4},  // R4 branch
      '{1'b1,24'hC0DEAD,1'b0,1'b0,1'b0,2'd0,1'b0, 1'b1,1'b1,1'b0,1'b0,1'b1,24'h000000,4'd4},  // R4 flush
      '{1'b1,24'hB00007,1'b0,1'b0,1'b1,2'd3,1'b0, 1'b1,1'b0,1'b0,1'b1,1'b0,24'hB00007,4'd4},  // R4 class 3 return
      '{1'b1,24'hC0DEAD,1'b0,1'b0,1'b0,2'd0,1'b0, 1'b1,1'b1,1'b0,1'b0,1'b1,24'h000000,4'd4},  // R4
      '{1'b1,24'hD00008,1'b0,1'b0,1'b0,2'd0,1'b0, 1'b0,1'b1,1'b0,1'b0,1'b0,24'h000000,4'd4},  // R4 held
      '{1'b1,24'hD00008,1'b1,1'b0,1'b0,2'd0,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0,24'hD00008,4'd5},  // R5 first
      '{1'b1,24'h001234,1'b0,1'b0,1'b0,2'd0,1'b0, 1'b1,1'b0,1'b1,1'b0,1'b0,24'h001234,4'd5},  // R5 second
      '{1'b1,24'hE00009,1'b1,1'b0,1'b1,2'd0,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0,24'hE00009,4'd5},  // R5 two-word jump
      '{1'b1,24'h005678,1'b0,1'b0,1'b0,2'd0,1'b0, 1'b1,1'b0,1'b1,1'b1,1'b0,24'h005678,4'd5},  // R5
      '{1'b1,24'hC0DEAD,1'b0,1'b0,1'b0,2'd0,1'b0, 1'b1,1'b1,1'b0,1'b0,1'b1,24'h000000,4'd5},  // R5 flush
      '{1'b1,24'hF0000A,1'b0,1'b1,1'b0,2'd0,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0,24'hF0000A,4'd6},  // R6 skip one
      '{1'b1,24'hF0000B,1'b0,1'b0,1'b0,2'd0,1'b0, 1'b1,1'b1,1'b0,1'b0,1'b0,24'h000000,4'd6},  // R6
      '{1'b1,24'hF0000C,1'b0,1'b1,1'b0,2'd0,1'b1, 1'b1,1'b0,1'b0,1'b0,1'b0,24'hF0000C,4'd7},  // R7 skip two
      '{1'b1,24'hF0000D,1'b1,1'b0,1'b0,2'd0,1'b0, 1'b1,1'b1,1'b0,1'b0,1'b0,24'h000000,4'd7},  // R7
      '{1'b1,24'h00ABCD,1'b0,1'b0,1'b0,2'd0,1'b0, 1'b1,1'b1,1'b0,1'b0,1'b0,24'h000000,4'd7},  // R7
      '{1'b1,24'h00BEEF,1'b1,1'b1,1'b1,2'd3,1'b1, 1'b1,1'b1,1'b0,1'b0,1'b0,24'h00BEEF,4'd8},  // R8 stray
      '{1'b1,24'hF0000E,1'b0,1'b0,1'b0,2'd0,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0,24'hF0000E,4'd8},  // R8 no bubble
      '{1'b0,24'hF0000F,1'b0,1'b0,1'b0,2'd0,1'b0, 1'b0,1'b1,1'b0,1'b0,1'b0,24'h000000,4'd9},  // R9 idle
      '{1'b1,24'hF0000F,1'b1,1'b0,1'b0,2'd0,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0,24'hF0000F,4'd5},  // R5
      '{1'b0,24'h000111,1'b0,1'b0,1'b0,2'd0,1'b0, 1'b0,1'b1,1'b0,1'b0,1'b0,24'h000000,4'd9},  // R9 wait
      '{1'b1,24'h000111,1'b0,1'b0,1'b0,2'd0,1'b0, 1'b1,1'b0,1'b1,1'b0,1'b0,24'h000111,4'd9},  // R9 kept
      '{1'b1,24'hA00010,1'b0,1'b0,1'b0,2'd1,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0,24'hA00010,4'd2}   // R2
   };
   localparam int NOPS_IN_TABLE = 14;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        fetch_valid = 1'b0;
   logic [23:0] fetch_word = '0;
   logic        hint_dword = 1'b0;
   logic        hint_skip = 1'b0;
   logic        hint_pc_chg = 1'b0;
   logic [1:0]  hint_class = '0;
   logic        hint_next_dword = 1'b0;
   logic        fetch_adv;
   logic [23:0] issue_word;
   logic        issue_nop;
   logic        issue_ext;
   logic        pc_redirect;
   logic        flush;
   logic [15:0] nop_count;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   issue_seq i_issue_seq (
      .clk             (clk),
      .rst             (rst),
      .fetch_valid     (fetch_valid),
      .fetch_word      (fetch_word),
      .hint_dword      (hint_dword),
      .hint_skip       (hint_skip),
      .hint_pc_chg     (hint_pc_chg),
      .hint_class      (hint_class),
      .hint_next_dword (hint_next_dword),
      .fetch_adv       (fetch_adv),
      .issue_word      (issue_word),
      .issue_nop       (issue_nop),
      .issue_ext       (issue_ext),
      .pc_redirect     (pc_redirect),
      .flush           (flush),
      .nop_count       (nop_count)
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic drive(input logic v, input logic [23:0] w, input logic dw,
                        input logic sk, input logic pc, input logic [1:0] cls,
                        input logic nd);
      fetch_valid     = v;
      fetch_word      = w;
      hint_dword      = dw;
      hint_skip       = sk;
      hint_pc_chg     = pc;
      hint_class      = cls;
      hint_next_dword = nd;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      // table walk; the first row is the cycle right after reset (R1)
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         rst = 1'b0;
         drive(VEC[i].v, VEC[i].w, VEC[i].dw, VEC[i].sk, VEC[i].pc, VEC[i].cls, VEC[i].nd);
         #1;
         begin
            string tg;
            tg = $sformatf("R%0d row %0d", VEC[i].rq, i);
            chk(tg, "fetch_adv",   32'(fetch_adv),   32'(VEC[i].e_adv));
            chk(tg, "issue_nop",   32'(issue_nop),   32'(VEC[i].e_nop));
            chk(tg, "issue_ext",   32'(issue_ext),   32'(VEC[i].e_ext));
            chk(tg, "pc_redirect", 32'(pc_redirect), 32'(VEC[i].e_red));
            chk(tg, "flush",       32'(flush),       32'(VEC[i].e_fl));
            chk(tg, "issue_word",  32'(issue_word),  32'(VEC[i].e_w));
         end
      end

      // R10: count of NOP slots over the whole table
      @(negedge clk);
      drive(1'b1, 24'hA00020, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0);
      #1;
      chk("R10", "nop_count after table", 32'(nop_count), 32'(NOPS_IN_TABLE));
      chk("R3", "class 3 issue", 32'(issue_word), 32'h00A00020);

      // R1: reset in the middle of a bubble run
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      drive(1'b1, 24'hA00021, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
      #1;
      chk("R1", "boot issue_nop", 32'(issue_nop), 32'd1);
      chk("R1", "boot fetch_adv", 32'(fetch_adv), 32'd0);
      chk("R1", "boot issue_word", 32'(issue_word), 32'd0);
      chk("R1", "nop_count cleared", 32'(nop_count), 32'd0);
      @(negedge clk);
      #1;
      chk("R1", "first word taken", 32'(fetch_adv), 32'd1);
      chk("R1", "first word issued", 32'(issue_word), 32'h00A00021);
      chk("R1", "nop_count after boot", 32'(nop_count), 32'd1);

      // R10: saturation under a long idle run
      @(negedge clk);
      drive(1'b0, 24'h000000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
      repeat (65540) @(posedge clk);
      @(negedge clk);
      #1;
      chk("R10", "nop_count saturated", 32'(nop_count), 32'h0000FFFF);
      chk("R9", "idle fetch_adv", 32'(fetch_adv), 32'd0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule